// File: doc/BRIEF.md
# Deferred Error Syndrome Capture Register

This block is a 64-bit status register that records a virtual asynchronous error after an error-synchronization barrier has held it back. A single-cycle deferral pulse makes the register build a syndrome word from a syndrome-source register and store it. The stored word sets a valid flag and copies the source fields. It also carries a fixed fault status code. The layout of the word depends on the guest's execution width. For a 32-bit guest it also depends on the translation-format input.

Software can also write the register directly through a 64-bit write port. Bits that are reserved in the layout that applies are cleared before the value is stored. The stored word drives the read port directly, so a capture can be read on the next cycle.

Top module: `dsyn_capture_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the register becomes all zeros, and `rd_data` reads zero in the following cycle.
- R2: `rd_data[63:32]` always reads zero, whatever is captured or written.
- R3: A capture (`defer_evt` high at a clock edge) sets bit 31 to 1 in every layout.
- R4: In wide-guest mode (`guest_narrow`=0), a capture stores `src_ids` in bit 24 and `src_iss` in bits 23:0. All other low bits except bit 31 are zero.
- R5: In narrow-guest mode with `long_fmt`=0, a capture stores `src_aet` in bits 15:14 and `src_ext` in bit 12. The status 0b10110 is split so that its bit 4 is in bit 10 and its bits 3:0 are in bits 3:0 (value 0x6). Bit 9 is 0 and every other low bit except 31 is zero.
- R6: In narrow-guest mode with `long_fmt`=1, a capture stores `src_aet` in bits 15:14 and `src_ext` in bit 12. Bit 9 is 1 and bits 5:0 hold 0b010001. Every other low bit except 31 is zero.
- R7: In narrow-guest mode, the `long_fmt` value sampled at the capture edge selects the layout and is copied into bit 9. In wide mode, `long_fmt`, `src_aet` and `src_ext` have no effect on the captured word. In narrow mode, `src_ids` and `src_iss` have no effect.
- R8: A captured word appears on `rd_data` in the cycle right after the capture edge, with no further step.
- R9: When `defer_evt` and `sw_wr_en` are both high at the same edge, the capture result is stored and the written value is discarded.
- R10: A software write keeps only the bits of the current layout and clears the rest. In wide mode it keeps bits 31, 24 and 23:0. In narrow mode, bit 9 of the written value selects the layout. With bit 9 = 0 it keeps bits 31, 15:14, 12, 10, 9 and 3:0. With bit 9 = 1 it keeps bits 31, 15:14, 12, 9 and 5:0.
- R11: In a cycle with neither a capture nor a write, the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| defer_evt | input | 1 | Deferral event pulse; starts a capture |
| guest_narrow | input | 1 | 1 = 32-bit guest layouts, 0 = 64-bit guest layout |
| long_fmt | input | 1 | Translation-format enable; picks the long layout in narrow mode |
| src_ids | input | 1 | Implementation-defined syndrome bit from the source register |
| src_iss | input | 24 | Syndrome field from the source register |
| src_aet | input | 2 | Error-type field from the source register |
| src_ext | input | 1 | External-abort flag from the source register |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 64 | Software write value |
| rd_data | output | 64 | Current register contents |

## Verification
The assertions assume that `rst` is applied from time zero, because the stability property relates each cycle's value to the one before it. They also assume that all inputs are known at every edge. Where a property depends on the layout, it uses the mode and format inputs sampled at the same edge as the event. The bench therefore changes all inputs only on the falling clock edge, so each edge sees one consistent set of inputs. Random stimulus is mixed with directed cases. It includes collisions between captures and writes, writes of all ones, and flips of the format input in wide mode.

// File: rtl/dsyn_pkg.sv
package dsyn_pkg;
    parameter int REG_W = 64;
    parameter int LOW_W = 32;
    parameter int ISS_W = 24;
    parameter int AET_W = 2;

    localparam int VALID_BIT = 31;
    localparam int IDS_BIT   = ISS_W;
    localparam int AET_LSB   = 14;
    localparam int EXT_BIT   = 12;
    localparam int SFS4_BIT  = 10;
    localparam int FMT_BIT   = 9;
    localparam int NUM_LAY   = 3;

    localparam logic [4:0] SHORT_STATUS = 5'b10110;
    localparam logic [5:0] LONG_STATUS  = 6'b010001;

    typedef enum logic [1:0] {
        LAY_WIDE  = 2'd0,
        LAY_SHORT = 2'd1,
        LAY_LONG  = 2'd2
    } layout_e;

    typedef struct packed {
        logic             ids;
        logic [ISS_W-1:0] iss;
        logic [AET_W-1:0] aet;
        logic             ext;
    } src_t;

    function automatic layout_e pick_layout(input logic narrow, input logic fmt);
        if (!narrow)  return LAY_WIDE;
        else if (fmt) return LAY_LONG;
        else          return LAY_SHORT;
    endfunction

    function automatic logic [REG_W-1:0] keep_mask(input layout_e lay);
        logic [REG_W-1:0] m;
        m = '0;
        m[VALID_BIT] = 1'b1;
        case (lay)
            LAY_WIDE: begin
                m[IDS_BIT] = 1'b1;
                m[ISS_W-1:0] = '1;
            end
            LAY_SHORT: begin
                m[AET_LSB+AET_W-1:AET_LSB] = '1;
                m[EXT_BIT]  = 1'b1;
                m[SFS4_BIT] = 1'b1;
                m[FMT_BIT]  = 1'b1;
                m[3:0]      = '1;
            end
            default: begin
                m[AET_LSB+AET_W-1:AET_LSB] = '1;
                m[EXT_BIT] = 1'b1;
                m[FMT_BIT] = 1'b1;
                m[5:0]     = '1;
            end
        endcase
        return m;
    endfunction
endpackage

// File: rtl/dsyn_layout_sel.sv
module dsyn_layout_sel
    import dsyn_pkg::*;
(
    input  logic    guest_narrow,
    input  logic    cap_fmt,
    input  logic    wr_fmt,
    output layout_e cap_lay,
    output layout_e wr_lay
);
    always_comb begin
        cap_lay = pick_layout(guest_narrow, cap_fmt);
        wr_lay  = pick_layout(guest_narrow, wr_fmt);
    end
endmodule

// File: rtl/dsyn_syndrome_fmt.sv
module dsyn_syndrome_fmt
    import dsyn_pkg::*;
(
    input  src_t             src,
    input  layout_e          lay,
    output logic [REG_W-1:0] word
);
    logic [REG_W-1:0] cand [NUM_LAY];

    for (genvar g = 0; g < NUM_LAY; g++) begin : g_lay
        if (g == int'(LAY_WIDE)) begin : g_wide
            always_comb begin
                cand[g] = '0;
                cand[g][VALID_BIT]  = 1'b1;
                cand[g][IDS_BIT]    = src.ids;
                cand[g][ISS_W-1:0]  = src.iss;
            end
        end else if (g == int'(LAY_SHORT)) begin : g_short
            always_comb begin
                cand[g] = '0;
                cand[g][VALID_BIT] = 1'b1;
                cand[g][AET_LSB+AET_W-1:AET_LSB] = src.aet;
                cand[g][EXT_BIT]  = src.ext;
                cand[g][SFS4_BIT] = SHORT_STATUS[4];
                cand[g][FMT_BIT]  = 1'b0;
                cand[g][3:0]      = SHORT_STATUS[3:0];
            end
        end else begin : g_long
            always_comb begin
                cand[g] = '0;
                cand[g][VALID_BIT] = 1'b1;
                cand[g][AET_LSB+AET_W-1:AET_LSB] = src.aet;
                cand[g][EXT_BIT] = src.ext;
                cand[g][FMT_BIT] = 1'b1;
                cand[g][5:0]     = LONG_STATUS;
            end
        end
    end

    always_comb begin
        case (lay)
            LAY_WIDE:  word = cand[0];
            LAY_SHORT: word = cand[1];
            default:   word = cand[2];
        endcase
    end
endmodule

// File: rtl/dsyn_wr_mask.sv
module dsyn_wr_mask
    import dsyn_pkg::*;
(
    input  logic [REG_W-1:0] wr_data,
    input  layout_e          lay,
    output logic [REG_W-1:0] kept
);
    always_comb kept = wr_data & keep_mask(lay);
endmodule

// File: rtl/dsyn_capture_reg.sv
module dsyn_capture_reg
    import dsyn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             defer_evt,
    input  logic             guest_narrow,
    input  logic             long_fmt,
    input  logic             src_ids,
    input  logic [ISS_W-1:0] src_iss,
    input  logic [AET_W-1:0] src_aet,
    input  logic             src_ext,
    input  logic             sw_wr_en,
    input  logic [REG_W-1:0] sw_wr_data,
    output logic [REG_W-1:0] rd_data
);
    layout_e          cap_lay;
    layout_e          wr_lay;
    src_t             src;
    logic [REG_W-1:0] cap_word;
    logic [REG_W-1:0] wr_word;
    logic [REG_W-1:0] state_q;

    always_comb begin
        src.ids = src_ids;
        src.iss = src_iss;
        src.aet = src_aet;
        src.ext = src_ext;
    end

    dsyn_layout_sel u_sel (
        .guest_narrow (guest_narrow),
        .cap_fmt      (long_fmt),
        .wr_fmt       (sw_wr_data[FMT_BIT]),
        .cap_lay      (cap_lay),
        .wr_lay       (wr_lay)
    );

    dsyn_syndrome_fmt u_fmt (
        .src  (src),
        .lay  (cap_lay),
        .word (cap_word)
    );

    dsyn_wr_mask u_mask (
        .wr_data (sw_wr_data),
        .lay     (wr_lay),
        .kept    (wr_word)
    );

    // capture outranks a software write in the same cycle
    always_ff @(posedge clk) begin
        if (rst)           state_q <= '0;
        else if (defer_evt) state_q <= cap_word;
        else if (sw_wr_en)  state_q <= wr_word;
    end

    assign rd_data = state_q;
endmodule

// File: rtl/dsyn_capture_chk.sv
module dsyn_capture_chk
    import dsyn_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             defer_evt,
    input logic             guest_narrow,
    input logic             long_fmt,
    input logic             src_ids,
    input logic [ISS_W-1:0] src_iss,
    input logic [AET_W-1:0] src_aet,
    input logic             src_ext,
    input logic             sw_wr_en,
    input logic [REG_W-1:0] sw_wr_data,
    input logic [REG_W-1:0] rd_data
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> rd_data == '0);
    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sw_wr_en |=> rd_data[REG_W-1:LOW_W] == '0);
    // R3
    valid_set_chk: assert property (@(posedge clk) disable iff (rst)
        defer_evt |=> rd_data[VALID_BIT]);
    // R4
    wide_copy_chk: assert property (@(posedge clk) disable iff (rst)
        defer_evt && !guest_narrow |=>
            rd_data[IDS_BIT:0] == $past({src_ids, src_iss}) && rd_data[30:25] == '0);
    // R5
    short_status_chk: assert property (@(posedge clk) disable iff (rst)
        defer_evt && guest_narrow && !long_fmt |=>
            rd_data[SFS4_BIT] && rd_data[3:0] == 4'b0110 && !rd_data[FMT_BIT]);
    // R6
    long_status_chk: assert property (@(posedge clk) disable iff (rst)
        defer_evt && guest_narrow && long_fmt |=>
            rd_data[5:0] == 6'b010001 && rd_data[FMT_BIT] && !rd_data[SFS4_BIT]);
    // R7
    narrow_fields_chk: assert property (@(posedge clk) disable iff (rst)
        defer_evt && guest_narrow |=>
            rd_data[15:14] == $past(src_aet) && rd_data[EXT_BIT] == $past(src_ext));
    // R9
    defer_wins_chk: assert property (@(posedge clk) disable iff (rst)
        defer_evt && sw_wr_en |=> rd_data[VALID_BIT]);
    // R10
    wr_wide_mask_chk: assert property (@(posedge clk) disable iff (rst)
        sw_wr_en && !defer_evt && !guest_narrow |=>
            rd_data[30:25] == '0 && rd_data[VALID_BIT] == $past(sw_wr_data[VALID_BIT]));
    // R10
    wr_long_mask_chk: assert property (@(posedge clk) disable iff (rst)
        sw_wr_en && !defer_evt && guest_narrow && sw_wr_data[FMT_BIT] |=>
            rd_data[11:10] == '0 && rd_data[8:6] == '0);
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !defer_evt && !sw_wr_en && !$past(rst) |=> $stable(rd_data));
endmodule

bind dsyn_capture_reg dsyn_capture_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .defer_evt    (defer_evt),
    .guest_narrow (guest_narrow),
    .long_fmt     (long_fmt),
    .src_ids      (src_ids),
    .src_iss      (src_iss),
    .src_aet      (src_aet),
    .src_ext      (src_ext),
    .sw_wr_en     (sw_wr_en),
    .sw_wr_data   (sw_wr_data),
    .rd_data      (rd_data)
);

// File: tb/dsyn_capture_reg_tb.sv
module dsyn_capture_reg_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        defer_evt = 1'b0;
    logic        guest_narrow = 1'b0;
    logic        long_fmt = 1'b0;
    logic        src_ids = 1'b0;
    logic [23:0] src_iss = '0;
    logic [1:0]  src_aet = '0;
    logic        src_ext = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [63:0] sw_wr_data = '0;
    logic [63:0] rd_data;

    logic [63:0] expv = '0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    dsyn_capture_reg u_dut (
        .clk(clk), .rst(rst), .defer_evt(defer_evt), .guest_narrow(guest_narrow),
        .long_fmt(long_fmt), .src_ids(src_ids), .src_iss(src_iss), .src_aet(src_aet),
        .src_ext(src_ext), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .rd_data(rd_data)
    );

    function automatic logic [63:0] model_next(input logic [63:0] cur);
        logic [63:0] n;
        n = cur;
        if (rst) begin
            n = '0;
        end else if (defer_evt) begin
            n = '0;
            n[31] = 1'b1;
            if (!guest_narrow) begin
                n[24] = src_ids;
                n[23:0] = src_iss;
            end else begin
                n[15:14] = src_aet;
                n[12] = src_ext;
                if (long_fmt) begin
                    n[9] = 1'b1;
                    n[5:0] = 6'h11;
                end else begin
                    n[10] = 1'b1;
                    n[3:0] = 4'h6;
                end
            end
        end else if (sw_wr_en) begin
            n = '0;
            n[31] = sw_wr_data[31];
            if (!guest_narrow) begin
                n[24:0] = sw_wr_data[24:0];
            end else begin
                n[15:14] = sw_wr_data[15:14];
                n[12] = sw_wr_data[12];
                n[9] = sw_wr_data[9];
                if (sw_wr_data[9]) n[5:0] = sw_wr_data[5:0];
                else begin
                    n[10] = sw_wr_data[10];
                    n[3:0] = sw_wr_data[3:0];
                end
            end
        end
        return n;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // one clock: model advances on the inputs now applied, compare after the edge
    task automatic step(input string req);
        expv = model_next(expv);
        @(posedge clk);
        @(negedge clk);
        check(req, rd_data, expv);
        check("R2", {32'd0, rd_data[63:32]}, 64'd0);
        rst = 1'b0; defer_evt = 1'b0; sw_wr_en = 1'b0;
    endtask

    task automatic capture(input string req, input logic nar, input logic lf, input logic ids,
                           input logic [23:0] iss, input logic [1:0] aet, input logic ext);
        guest_narrow = nar; long_fmt = lf; src_ids = ids; src_iss = iss;
        src_aet = aet; src_ext = ext; defer_evt = 1'b1;
        step(req);
    endtask

    task automatic swrite(input string req, input logic nar, input logic [63:0] d);
        guest_narrow = nar; sw_wr_data = d; sw_wr_en = 1'b1;
        step(req);
    endtask

    initial begin
        @(negedge clk);
        rst = 1'b1;
        step("R1");
        check("R1", rd_data, 64'd0);
        capture("R4", 1'b0, 1'b0, 1'b1, 24'hABCDEF, 2'b11, 1'b1);
        check("R4", rd_data, 64'h0000_0000_81AB_CDEF);
        check("R8", {63'd0, rd_data[31]}, 64'd1);
        capture("R7", 1'b0, 1'b1, 1'b0, 24'h123456, 2'b10, 1'b0);
        check("R7", rd_data, 64'h0000_0000_8012_3456);
        capture("R5", 1'b1, 1'b0, 1'b1, 24'hFFFFFF, 2'b10, 1'b1);
        check("R5", rd_data, 64'h0000_0000_8000_9406);
        capture("R6", 1'b1, 1'b1, 1'b1, 24'hFFFFFF, 2'b01, 1'b0);
        check("R6", rd_data, 64'h0000_0000_8000_4211);
        capture("R3", 1'b1, 1'b1, 1'b0, 24'h0, 2'b00, 1'b0);
        check("R3", rd_data, 64'h0000_0000_8000_0211);
        step("R11");
        step("R11");
        check("R11", rd_data, 64'h0000_0000_8000_0211);
        swrite("R10", 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R10", rd_data, 64'h0000_0000_81FF_FFFF);
        swrite("R10", 1'b1, 64'hFFFF_FFFF_FFFF_FDFF);
        check("R10", rd_data, 64'h0000_0000_8000_D40F);
        swrite("R10", 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R10", rd_data, 64'h0000_0000_8000_D23F);
        guest_narrow = 1'b0; src_ids = 1'b0; src_iss = 24'h000042;
        sw_wr_data = 64'hFFFF_FFFF_FFFF_FFFF; sw_wr_en = 1'b1; defer_evt = 1'b1;
        step("R9");
        check("R9", rd_data, 64'h0000_0000_8000_0042);
        rst = 1'b1;
        step("R1");
        check("R1", rd_data, 64'd0);
        for (int i = 0; i < 3000; i++) begin
            guest_narrow = 1'($urandom);
            long_fmt = 1'($urandom);
            src_ids = 1'($urandom);
            src_iss = 24'($urandom);
            src_aet = 2'($urandom);
            src_ext = 1'($urandom);
            sw_wr_data = {32'($urandom), 32'($urandom)};
            defer_evt = ($urandom % 4) == 0;
            sw_wr_en = ($urandom % 3) == 0;
            rst = ($urandom % 200) == 0;
            step("R11 random");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule